// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block sits behind a nine-stage pipelined analog-to-digital converter built from redundant 1.5-bit stages. Each stage delivers a 2-bit decision, and the stages resolve a given sample at different times: odd and even stages run on opposite phases of the clock, so each stage decides half a clock period after the one before it. The block lines up all nine decisions that belong to one sample and produces one corrected 10-bit result per clock once its pipeline has filled.

The alignment network is a set of skewed shift registers. Stage `i` is captured on the clock edge opposite to the one on which it changes. It then moves through a chain of registers that alternate between the falling and rising edges, so that every stage of one sample arrives at the same falling edge. A rising-edge summing register then folds the redundant codes together. Each code is weighted by twice the weight of the stage after it, and the weighted codes are added rather than concatenated. The raw, uncorrected codes of the first four stages come out on a separate tap bus, aligned with the corrected word of the same sample. A stage code of 11 is treated as 10 in the sum and latches an error flag.

Top module: `adc_corr_top`

## Requirements
- R1: The corrected word is the sum, over stages i = 0..8, of stage i's 2-bit code shifted left by (8 − i). Stage i's code is `stageBits[2i+1:2i]`, and stage 0 is the first (most significant) stage. The sum is at most 1022 and is never wrapped or saturated.
- R2: Even-numbered stages of sample s change just after rising edge number 2s+i, and odd-numbered stages change just after the falling edge with that count. Edges are counted from edge 0, the first rising edge with `rstN` high. The result for sample s appears on `codeOut` just after rising edge s+5, so one new word follows every clock.
- R3: `codeValid` is low after reset. It rises just after rising edge 5, together with the result of sample 0, and then stays high every cycle until the next reset.
- R4: A stage code of 11 adds as if it were 10. `codeOut` therefore never shows 1023 while valid.
- R5: `errFlag` rises together with the output word of the first valid sample that contains a code 11 in any stage. It stays high until reset.
- R6: `rawTap[2i+1:2i]` for i = 0..3 shows the unmodified code of stage i of the same sample shown on `codeOut`, including a raw 11.
- R7: While `rstN` is low at a rising edge (synchronous, active low), `codeOut`, `rawTap`, `codeValid` and `errFlag` are all zero after that edge.
- R8: The input is an ideal ramp over full scale. It is quantized by ideal stages with decision thresholds at ±¼ of the reference, each stage passing on twice its residue. Under that input, every output lies within one LSB of the rounded ideal value 512·x + 511, where x ∈ [−1, 1] is the normalized input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rstN | input | 1 | Synchronous reset, active low |
| stageBits | input | 18 | Stage decisions; stage i at bits [2i+1:2i] |
| codeOut | output | 10 | Corrected result |
| codeValid | output | 1 | High while codeOut carries a real sample |
| rawTap | output | 8 | Uncorrected codes of stages 0..3, aligned to codeOut |
| errFlag | output | 1 | Sticky flag: an illegal code 11 was seen |

## Verification
A stream of single-stage patterns gives each sample its own non-zero code in exactly one stage. A misplaced skew register or a wrong shift weight therefore shows up as a word from a neighbouring sample or as a power-of-two error. The valid strobe is checked on every cycle from reset: a latency counter that is off by one raises valid over a fill word, or drops the word of sample 0. Illegal codes are placed first in a stage beyond the debug taps and later inside them. This catches a missing clamp, which would produce 1023 or an overflowed sum, a flag that is not sticky, and a tap that shows clamped data. A full-scale ramp from ideal stages and a reset in the middle of a run complete the set. The ramp exposes swapped weights as multi-LSB errors, and the reset shows whether the flag and the fill state are really cleared.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;

  // Strobes from the fill controller to the datapath
  typedef struct packed {
    logic sumLive;   // the coming rising edge sums a real sample
    logic outValid;  // codeOut holds a real sample
  } corrStrb_t;

  // Code 11 is outside the redundant alphabet; it is folded onto 10
  function automatic logic [1:0] clampCode(input logic [1:0] code);
    return (code == 2'b11) ? 2'b10 : code;
  endfunction

endpackage

// File: rtl/adc_corr_ctrl.sv
`timescale 1ns/1ps
module adc_corr_ctrl
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 9
) (
  input  logic      clk,
  input  logic      rstN,
  output corrStrb_t strb
);
  // The last stage lands on falling edge NUM_STAGES (odd); the summing
  // register follows on the next rising edge.
  localparam int FILL_EDGES = (NUM_STAGES + 1) / 2 + 1;
  localparam int CNT_W      = $clog2(FILL_EDGES + 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (fillCnt != CNT_W'(FILL_EDGES)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strb.sumLive  = (fillCnt >= CNT_W'(FILL_EDGES - 1));
    strb.outValid = (fillCnt == CNT_W'(FILL_EDGES));
  end

endmodule

// File: rtl/adc_corr_skew.sv
`timescale 1ns/1ps
module adc_corr_skew #(
  parameter int NUM_STAGES = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [2*NUM_STAGES-1:0]       stageBits,
  output logic [NUM_STAGES-1:0][1:0]    aligned
);
  // Stage i changes after edge 2s+i; hop k of its chain fires on edge
  // 2s+i+1+k, alternating falling/rising, so all chains end on edge 2s+NUM_STAGES.
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int DEPTH = NUM_STAGES - i;
    for (genvar k = 0; k < DEPTH; k++) begin : g_hop
      logic [1:0] hopIn;
      logic [1:0] q;
      if (k == 0) begin : g_head
        assign hopIn = stageBits[2*i +: 2];
      end else begin : g_link
        assign hopIn = g_hop[k-1].q;
      end
      if (((i + 1 + k) % 2) == 1) begin : g_fall
        always_ff @(negedge clk) begin
          if (!rstN) q <= 2'b00;
          else       q <= hopIn;
        end
      end else begin : g_rise
        always_ff @(posedge clk) begin
          if (!rstN) q <= 2'b00;
          else       q <= hopIn;
        end
      end
    end
    assign aligned[i] = g_hop[DEPTH-1].q;
  end

endmodule

// File: rtl/adc_corr_sum.sv
`timescale 1ns/1ps
module adc_corr_sum
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 9,
  parameter int TAP_STAGES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  corrStrb_t                     strb,
  input  logic [NUM_STAGES-1:0][1:0]    aligned,
  output logic [NUM_STAGES:0]           codeOut,
  output logic [2*TAP_STAGES-1:0]       rawTap,
  output logic                          errFlag
);
  localparam int OUT_W = NUM_STAGES + 1;

  logic [OUT_W-1:0]      sumNext;
  logic                  anyIllegal;
  logic [2*TAP_STAGES-1:0] tapNext;

  // Overlap-add: stage i carries weight 2^(NUM_STAGES-1-i)
  always_comb begin
    sumNext    = '0;
    anyIllegal = 1'b0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      sumNext    = sumNext + (OUT_W'(clampCode(aligned[i])) << (NUM_STAGES - 1 - i));
      anyIllegal = anyIllegal | (aligned[i] == 2'b11);
    end
  end

  for (genvar t = 0; t < TAP_STAGES; t++) begin : g_tap
    assign tapNext[2*t +: 2] = aligned[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeOut <= '0;
      rawTap  <= '0;
      errFlag <= 1'b0;
    end else begin
      codeOut <= sumNext;
      rawTap  <= tapNext;
      errFlag <= errFlag | (strb.sumLive & anyIllegal);
    end
  end

endmodule

// File: rtl/adc_corr_datapath.sv
`timescale 1ns/1ps
module adc_corr_datapath
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 9,
  parameter int TAP_STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  corrStrb_t                 strb,
  input  logic [2*NUM_STAGES-1:0]   stageBits,
  output logic [NUM_STAGES:0]       codeOut,
  output logic [2*TAP_STAGES-1:0]   rawTap,
  output logic                      errFlag
);
  logic [NUM_STAGES-1:0][1:0] aligned;

  adc_corr_skew #(.NUM_STAGES(NUM_STAGES)) skew_i (
    .clk      (clk),
    .rstN     (rstN),
    .stageBits(stageBits),
    .aligned  (aligned)
  );

  adc_corr_sum #(.NUM_STAGES(NUM_STAGES), .TAP_STAGES(TAP_STAGES)) sum_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .aligned(aligned),
    .codeOut(codeOut),
    .rawTap (rawTap),
    .errFlag(errFlag)
  );

endmodule

// File: rtl/adc_corr_top.sv
`timescale 1ns/1ps
module adc_corr_top
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 9,   // must be odd
  parameter int TAP_STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2*NUM_STAGES-1:0]   stageBits,
  output logic [NUM_STAGES:0]       codeOut,
  output logic                      codeValid,
  output logic [2*TAP_STAGES-1:0]   rawTap,
  output logic                      errFlag
);
  corrStrb_t strb;

  adc_corr_ctrl #(.NUM_STAGES(NUM_STAGES)) ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .strb(strb)
  );

  adc_corr_datapath #(.NUM_STAGES(NUM_STAGES), .TAP_STAGES(TAP_STAGES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stageBits(stageBits),
    .codeOut  (codeOut),
    .rawTap   (rawTap),
    .errFlag  (errFlag)
  );

  assign codeValid = strb.outValid;

endmodule

// File: rtl/adc_corr_chk.sv
`timescale 1ns/1ps
module adc_corr_chk #(
  parameter int NUM_STAGES = 9,
  parameter int TAP_STAGES = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_STAGES:0]     codeOut,
  input logic                    codeValid,
  input logic [2*TAP_STAGES-1:0] rawTap,
  input logic                    errFlag
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> codeValid);  // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);  // R5

  AST_NO_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (codeOut != '1));  // R4

  for (genvar t = 0; t < TAP_STAGES; t++) begin : g_tapchk
    AST_TAP_ILLEGAL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
      (codeValid && (rawTap[2*t +: 2] == 2'b11)) |-> errFlag);  // R5
  end

endmodule

bind adc_corr_top adc_corr_chk #(.NUM_STAGES(NUM_STAGES), .TAP_STAGES(TAP_STAGES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .codeOut  (codeOut),
  .codeValid(codeValid),
  .rawTap   (rawTap),
  .errFlag  (errFlag)
);

// File: tb/adc_corr_top_tb_top.sv
`timescale 1ns/1ps
module adc_corr_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] stageBits = '0;
  logic [9:0]  codeOut;
  logic        codeValid;
  logic [7:0]  rawTap;
  logic        errFlag;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [17:0] sampMem  [0:2047];
  int          idealMem [0:2047];
  bit          tolOn;

  always #2.5 clk = ~clk;

  adc_corr_top dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .stageBits(stageBits),
    .codeOut  (codeOut),
    .codeValid(codeValid),
    .rawTap   (rawTap),
    .errFlag  (errFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Weighted overlap-add of the requirement, with 11 counted as 10
  function automatic int wsum(input logic [17:0] v);
    int acc = 0;
    for (int i = 0; i < 9; i++) begin
      logic [1:0] c;
      c = v[2*i +: 2];
      if (c == 2'b11) c = 2'b10;
      acc += int'(c) << (8 - i);
    end
    return acc;
  endfunction

  function automatic bit hasIllegal(input logic [17:0] v);
    for (int i = 0; i < 9; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  // Ideal 1.5-bit stages, input scaled so that full scale is +-4096
  function automatic logic [17:0] quantize(input int x);
    int r = x;
    logic [17:0] v = '0;
    for (int i = 0; i < 9; i++) begin
      if (r > 1024) begin
        v[2*i +: 2] = 2'b10; r = 2*r - 4096;
      end else if (r < -1024) begin
        v[2*i +: 2] = 2'b00; r = 2*r + 4096;
      end else begin
        v[2*i +: 2] = 2'b01; r = 2*r;
      end
    end
    return v;
  endfunction

  // R7: reset state checked while rstN is low, then released after a falling edge
  task automatic doReset(input bit chk);
    rstN = 1'b0;
    stageBits = '0;
    repeat (3) @(posedge clk);
    #1.5;
    if (chk) begin
      check(codeOut == 0,    "R7 codeOut in reset", codeOut, 0);
      check(rawTap == 0,     "R7 rawTap in reset", rawTap, 0);
      check(codeValid == 0,  "R7 codeValid in reset", codeValid, 0);
      check(errFlag == 0,    "R7 errFlag in reset", errFlag, 0);
    end
    @(negedge clk);
    #0.5;
    rstN = 1'b1;
  endtask

  // Drives n samples with the two-phase stage timing and checks every output cycle
  task automatic runStream(input int n, input string req);
    bit errSeen = 1'b0;
    for (int e = 0; e <= 2*n + 10; e++) begin
      if (e % 2 == 0) @(posedge clk); else @(negedge clk);
      #0.5;
      for (int i = 0; i < 9; i++) begin
        if (e >= i && ((e - i) % 2 == 0)) begin
          int s;
          s = (e - i) / 2;
          stageBits[2*i +: 2] = (s < n) ? sampMem[s][2*i +: 2] : 2'b01;
        end
      end
      if (e % 2 == 0) begin
        int r;
        r = e / 2;
        #1.0;
        check(codeValid == (r >= 5), "R3 codeValid timing", codeValid, int'(r >= 5));
        if (r >= 5 && (r - 5) < n) begin
          int s;
          logic [17:0] v;
          s = r - 5;
          v = sampMem[s];
          if (hasIllegal(v)) errSeen = 1'b1;
          check(int'(codeOut) == wsum(v), {req, " codeOut"}, codeOut, wsum(v));
          check(rawTap == v[7:0], "R6 rawTap", rawTap, v[7:0]);
          check(errFlag == errSeen, "R5 errFlag", errFlag, errSeen);
          if (tolOn) begin
            int d;
            d = int'(codeOut) - idealMem[s];
            check(d <= 1 && d >= -1, "R8 ramp error", codeOut, idealMem[s]);
          end
        end
      end
    end
  endtask

  // R1 / R2: fixed patterns, then one stage at a time to expose weights and skew
  task automatic testPatterns();
    int n = 0;
    sampMem[n++] = 18'h00000;                // all 00 -> 0
    sampMem[n++] = {9{2'b01}};               // all 01 -> 511
    sampMem[n++] = {9{2'b10}};               // all 10 -> 1022
    sampMem[n++] = {2'b10, {4{2'b00, 2'b10}}};
    for (int i = 0; i < 9; i++) begin
      logic [17:0] v = '0;
      v[2*i +: 2] = 2'b10;
      sampMem[n++] = v;
    end
    for (int i = 0; i < 9; i++) begin
      logic [17:0] v = {9{2'b01}};
      v[2*i +: 2] = 2'b00;
      sampMem[n++] = v;
    end
    tolOn = 1'b0;
    doReset(1'b1);
    runStream(n, "R1 R2");
    check(wsum({9{2'b10}}) == 1022, "R1 full-scale weight", wsum({9{2'b10}}), 1022);
  endtask

  // R4 / R5: illegal code beyond the taps first, then inside the taps
  task automatic testIllegal();
    int n = 0;
    for (int k = 0; k < 3; k++) sampMem[n++] = quantize(k * 700 - 700);
    sampMem[n]  = {9{2'b01}};
    sampMem[n][13:12] = 2'b11;
    n++;
    for (int k = 0; k < 3; k++) sampMem[n++] = quantize(1500 - k * 900);
    sampMem[n] = {9{2'b10}};
    sampMem[n][3:2] = 2'b11;
    n++;
    sampMem[n++] = {9{2'b11}};
    sampMem[n++] = 18'h00000;
    tolOn = 1'b0;
    doReset(1'b0);
    runStream(n, "R4");
  endtask

  // R7 after a dirty run: reset clears the sticky flag and the fill state
  task automatic testMidReset();
    int n = 0;
    for (int k = 0; k < 12; k++) sampMem[n++] = quantize(k * 600 - 3300);
    tolOn = 1'b0;
    doReset(1'b1);
    runStream(n, "R2 after reset");
  endtask

  // R8: full-scale ramp through ideal stages
  task automatic testRamp();
    int n = 0;
    for (int x = -4096; x <= 4096; x += 8) begin
      sampMem[n]  = quantize(x);
      idealMem[n] = (512*x + 512*4096 + 2048) / 4096 - 1;
      n++;
    end
    tolOn = 1'b1;
    doReset(1'b0);
    runStream(n, "R8 R1");
  endtask

  initial begin
    testPatterns();
    testIllegal();
    testMidReset();
    testRamp();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule